// File: doc/BRIEF.md
# Bitfield Extract/Insert and Byte-Swap Unit

This block is a registered 64-bit bit-manipulation unit for an integer datapath. Each accepted strobe performs one of four operations:

- **Extract** pulls a field out of the source operand.
- **Insert** merges a field of the source operand into a destination operand.
- **Byte swap** exchanges the two bytes of every 16-bit halfword.
- **Halfword shuffle** reverses the order of the four halfwords of the doubleword.

Results appear on the outputs one clock after the strobe.

A mode input selects between a 64-bit and a 32-bit word. In 32-bit mode, extract, insert and byte-swap results are sign-extended from bit 31. For extract and insert, the field is described by a 6-bit bit offset and a 7-bit field length. The unit does no instruction decoding. It only flags a field that does not fit the selected word width, and returns zero when it does.

Top module: `bitfield_unit`

## Requirements
- R1: Extract (op code 0) returns the source shifted right by the offset, with only the low `len` bits kept and all higher bits zero.
- R2: An extract with length 64 and offset 0 in 64-bit mode returns the complete source operand unchanged.
- R3: In 32-bit mode (`wide`=0), results of extract, insert and byte swap have bits 63..32 equal to bit 31.
- R4: Insert (op code 1) returns the destination with bits offset..offset+len-1 replaced by the low `len` bits of the source. All other destination bits are kept.
- R5: For extract or insert, if `len` is 0 or offset+len exceeds the word width (32 when `wide`=0, 64 when `wide`=1), `out_err` is 1 and `result` is 0. Otherwise `out_err` is 0.
- R6: Byte swap (op code 2) places byte 2k+1 of the source into byte 2k of the result, and byte 2k into byte 2k+1, for every halfword k.
- R7: Halfword shuffle (op code 3) puts source halfword 3-k into result halfword k. It ignores `wide`, `fld_off` and `fld_len`, and never sets `out_err`.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Without a strobe, `result` and `out_err` keep their values.
- R9: A synchronous active-high reset clears `out_valid`, `result` and `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 extract, 1 insert, 2 byte swap, 3 halfword shuffle |
| wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| src | input | 64 | Source operand |
| dst | input | 64 | Destination operand for insert |
| fld_off | input | 6 | Field bit offset |
| fld_len | input | 7 | Field length in bits (1 to 64 legal) |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| result | output | 64 | Registered result |
| out_err | output | 1 | Field did not fit the selected width |

## Verification
Extract and insert are driven with narrow fields in the middle of the word, with fields touching the top bit, and with the full-length field. These cases separate a correct mask from one that is off by one or that overflows at length 64. The 32-bit mode cases use sources whose bit 31 is set and cleared, which shows whether sign extension comes from the right bit. Illegal fields with length zero, just past 32, past 64 and a length above 64 show which bound check is wrong. Byte swap and shuffle use operands with every byte distinct, so any misrouted byte or halfword is visible. The shuffle is also run in both modes to show that the mode has no effect on it.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [1:0] {
    OP_EXTRACT = 2'd0,
    OP_INSERT  = 2'd1,
    OP_BSWAP   = 2'd2,
    OP_HSHUF   = 2'd3
  } bfu_op_e;

  localparam int DATA_W = 64;
  localparam int POS_W  = 6;
  localparam int SIZE_W = 7;

  function automatic logic [DATA_W-1:0] sext_low(input logic [DATA_W-1:0] v);
    return {{(DATA_W/2){v[DATA_W/2-1]}}, v[DATA_W/2-1:0]};
  endfunction
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 7
) (
  input  logic [SIZE_W-1:0] len,
  output logic [DATA_W-1:0] mask
);
  // bit i is set when i lies below the field length; length >= DATA_W gives all ones
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = (SIZE_W'(i) < len);
  end
endmodule

// File: rtl/bfu_field_core.sv
module bfu_field_core #(
  parameter int DATA_W = 64,
  parameter int POS_W  = 6,
  parameter int SIZE_W = 7
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [POS_W-1:0]  off,
  input  logic [SIZE_W-1:0] len,
  input  logic              wide,
  input  logic              is_ins,
  output logic [DATA_W-1:0] res,
  output logic              err
);
  localparam int HALF_W = DATA_W / 2;
  localparam int SUM_W  = SIZE_W + 1;

  logic [DATA_W-1:0] len_mask;
  logic [DATA_W-1:0] place_mask;
  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] ins_val;
  logic [DATA_W-1:0] raw;
  logic [SUM_W-1:0]  span_end;
  logic [SUM_W-1:0]  limit;

  bfu_mask_gen #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_mask (
    .len  (len),
    .mask (len_mask)
  );

  always_comb begin
    span_end   = SUM_W'(off) + SUM_W'(len);
    limit      = wide ? SUM_W'(DATA_W) : SUM_W'(HALF_W);
    err        = (len == '0) || (span_end > limit);
    place_mask = len_mask << off;
    ext_val    = (src >> off) & len_mask;
    ins_val    = (dst & ~place_mask) | ((src << off) & place_mask);
    raw        = is_ins ? ins_val : ext_val;
    if (err)
      res = '0;
    else if (!wide)
      res = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
    else
      res = raw;
  end
endmodule

// File: rtl/bfu_swap_core.sv
module bfu_swap_core #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] bswap,
  output logic [DATA_W-1:0] hshuf
);
  localparam int NHALF  = DATA_W / 16;
  localparam int NWORD  = DATA_W / 32;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] stage1;

  for (genvar h = 0; h < NHALF; h++) begin : g_hw
    assign bswap[16*h +: 8]     = src[16*h + 8 +: 8];
    assign bswap[16*h + 8 +: 8] = src[16*h +: 8];
  end

  // stage 1: swap neighbouring halfwords inside each 32-bit word
  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign stage1[32*w +: 16]      = src[32*w + 16 +: 16];
    assign stage1[32*w + 16 +: 16] = src[32*w +: 16];
  end

  // stage 2: swap the two halves of the full word
  assign hshuf = {stage1[HALF_W-1:0], stage1[DATA_W-1:HALF_W]};
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int DATA_W = bfu_pkg::DATA_W,
  parameter int POS_W  = bfu_pkg::POS_W,
  parameter int SIZE_W = bfu_pkg::SIZE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [POS_W-1:0]  fld_off,
  input  logic [SIZE_W-1:0] fld_len,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              out_err
);
  localparam int HALF_W = DATA_W / 2;

  bfu_op_e           op_e;
  logic [DATA_W-1:0] field_res;
  logic              field_err;
  logic [DATA_W-1:0] bswap_res;
  logic [DATA_W-1:0] hshuf_res;
  logic [DATA_W-1:0] next_res;
  logic              next_err;

  assign op_e = bfu_op_e'(op);

  bfu_field_core #(.DATA_W(DATA_W), .POS_W(POS_W), .SIZE_W(SIZE_W)) u_field (
    .src    (src),
    .dst    (dst),
    .off    (fld_off),
    .len    (fld_len),
    .wide   (wide),
    .is_ins (op_e == OP_INSERT),
    .res    (field_res),
    .err    (field_err)
  );

  bfu_swap_core #(.DATA_W(DATA_W)) u_swap (
    .src   (src),
    .bswap (bswap_res),
    .hshuf (hshuf_res)
  );

  always_comb begin
    next_err = 1'b0;
    unique case (op_e)
      OP_EXTRACT, OP_INSERT: begin
        next_res = field_res;
        next_err = field_err;
      end
      OP_BSWAP: next_res = wide ? bswap_res : sext_low(bswap_res);
      default:  next_res = hshuf_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_res;
        out_err <= next_err;
      end
    end
  end

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(out_err)));
  p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (result == '0));
  p_sext_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide && op != 2'd3) |=>
      (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}}));
  p_shuf_no_err_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd3) |=> !out_err);
endmodule

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  typedef struct {
    logic [63:0] res;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic        wide = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] dst = '0;
  logic [5:0]  fld_off = '0;
  logic [6:0]  fld_len = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        out_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  bitfield_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
    .src(src), .dst(dst), .fld_off(fld_off), .fld_len(fld_len),
    .out_valid(out_valid), .result(result), .out_err(out_err)
  );

  function automatic exp_t model(input logic [1:0] o, input logic w,
                                 input logic [63:0] s, input logic [63:0] d,
                                 input int p, input int n, input string tag);
    exp_t e;
    int width;
    logic [63:0] r;
    width = w ? 64 : 32;
    e.tag = tag;
    e.err = 1'b0;
    r = '0;
    if (o == 2'd0 || o == 2'd1) begin
      if (n == 0 || p + n > width) begin
        e.err = 1'b1;
        e.res = '0;
        return e;
      end
      if (o == 2'd0) begin
        for (int i = 0; i < n; i++) r[i] = s[p + i];
      end else begin
        r = d;
        for (int i = 0; i < n; i++) r[p + i] = s[i];
      end
      if (!w) for (int i = 32; i < 64; i++) r[i] = r[31];
    end else if (o == 2'd2) begin
      for (int h = 0; h < 4; h++) begin
        r[16*h +: 8]     = s[16*h + 8 +: 8];
        r[16*h + 8 +: 8] = s[16*h +: 8];
      end
      if (!w) for (int i = 32; i < 64; i++) r[i] = r[31];
    end else begin
      for (int h = 0; h < 4; h++) r[16*h +: 16] = s[16*(3 - h) +: 16];
    end
    e.res = r;
    return e;
  endfunction

  task automatic issue(input logic [1:0] o, input logic w, input logic [63:0] s,
                       input logic [63:0] d, input int p, input int n, input string tag);
    @(negedge clk);
    sb.push_back(model(o, w, s, d, p, n, tag));
    op = o; wide = w; src = s; dst = d;
    fld_off = 6'(p); fld_len = 7'(n);
    in_valid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each produced result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R8 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " result"}, result, e.res);
        check({e.tag, " err"}, {63'd0, out_err}, {63'd0, e.err});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] A = 64'h0123456789ABCDEF;
  localparam logic [63:0] B = 64'hFEDCBA9876543210;
  localparam logic [63:0] C = 64'h1122334455667788;

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    check("R9 reset err", {63'd0, out_err}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    issue(2'd0, 1'b1, A, 0, 4, 8, "R1 extract mid");
    issue(2'd0, 1'b1, A, 0, 60, 4, "R1 extract top");
    issue(2'd0, 1'b1, B, 0, 0, 64, "R2 extract full");
    issue(2'd0, 1'b0, A, 0, 0, 32, "R3 extract narrow neg");
    issue(2'd0, 1'b0, A, 0, 24, 8, "R3 extract narrow");
    issue(2'd1, 1'b1, A, B, 8, 12, "R4 insert mid");
    issue(2'd1, 1'b1, C, B, 32, 32, "R4 insert top");
    issue(2'd1, 1'b0, 64'hFFFF, 64'h0, 24, 8, "R4 R3 insert narrow sext");
    issue(2'd1, 1'b0, A, 64'hFFFF_FFFF_0000_0000, 4, 4, "R3 insert narrow pos");
    issue(2'd0, 1'b1, A, 0, 3, 0, "R5 len zero");
    issue(2'd0, 1'b0, A, 0, 30, 3, "R5 narrow overflow");
    issue(2'd1, 1'b0, A, B, 28, 4, "R5 narrow exact fit");
    issue(2'd1, 1'b1, A, B, 60, 8, "R5 wide overflow");
    issue(2'd0, 1'b1, A, 0, 0, 100, "R5 len above 64");
    issue(2'd2, 1'b1, A, 0, 0, 0, "R6 bswap wide");
    issue(2'd2, 1'b0, C, 0, 0, 0, "R6 R3 bswap narrow");
    issue(2'd3, 1'b1, A, 0, 0, 0, "R7 shuffle wide");
    issue(2'd3, 1'b0, B, 0, 63, 0, "R7 shuffle narrow ignored");
    idle();
    @(negedge clk);
    held = result;
    check("R8 no strobe valid low", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R8 result held", result, held);
    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 64'(sb.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule